// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector with Loss Monitor

This block picks the system clock from four free-running oscillator inputs: a fast crystal, a slow crystal, a fast internal RC and a slow internal RC. A source is taken out of service on its own falling edges before the next source is let through on its own falling edges, so the output never shows a shortened pulse. A power-of-two prescaler follows the selector. It is built as a gate on the selected clock, so each output pulse is one full high phase of the source and the output period is the source period times 2^d.

Software-style control arrives as a write strobe with a source code and a divide code, in the register clock domain. A status output stays high while a change is in flight. A write made during a change is parked and carried out once the change finishes. A loss monitor counts cycles of the fast internal RC. If no rising edge of the system clock arrives within a configurable number of those cycles while no change is in flight, it clears the control setting back to the fast internal RC with divide code 1 and forces the stalled branch off.

Top module: `clk_source_mux`

## Requirements
- R1: After reset the setting is source 2 (fast internal RC) with divide code 1, `switchBusy` is high until that source runs, and the output period then equals twice the fast RC period.
- R2: Source codes are 0 = fast crystal, 1 = slow crystal, 2 = fast internal RC, 3 = slow internal RC. Once a change completes, the output follows the selected source, and while no change or loss event is in flight that source's branch is enabled.
- R3: Divide code d (0 to 7) gives an output period of 2^d source periods, with every high phase equal to one source high phase.
- R4: At most one source branch is enabled at any time, and no output high or low phase is shorter than the shortest source half period.
- R5: A write accepted while idle appears on `curSel`/`curDiv` in the next register clock cycle, with `switchBusy` high in that cycle.
- R6: A change toward a source whose ready input is low stays pending, with `switchBusy` high, until ready rises; the change then completes.
- R7: A write made while `switchBusy` is high leaves `curSel`/`curDiv` unchanged until the change in flight ends. It is then carried out as the next change.
- R8: If no output rising edge arrives for `monTimeout` fast RC cycles while idle, the setting returns to source 2 with divide code 1 and a new change starts.
- R9: The monitor does not act while output edges arrive within the timeout, so a written setting stays in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| regClk | input | 1 | Register/control clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscClk | input | 4 | Oscillator clocks, indexed by source code |
| oscReady | input | 4 | Per-source ready indication |
| wrEn | input | 1 | Control write strobe |
| wrSel | input | 2 | Source code to write |
| wrDiv | input | 3 | Divide code to write |
| monTimeout | input | TO_W (8) | Loss timeout in fast RC cycles |
| sysClk | output | 1 | Selected, divided system clock |
| switchBusy | output | 1 | High while a change is in flight |
| curSel | output | 2 | Current source setting |
| curDiv | output | 3 | Current divide setting |

## Verification
On every register clock cycle, the assertions check that at most one branch is enabled. They also check that an idle write lands on the setting outputs one cycle later, that the setting is frozen while a change is in flight, that a loss event loads the RC default, and that the selected branch is enabled whenever the block is idle. What those checks cannot see is the output waveform. Only the bench's scenarios show the measured period and high phase for each source and divide code, the minimum pulse width across all changes, the stall on a source that is not ready, and the recovery after a crystal stops.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  localparam int NUM_SRC   = 4;
  localparam int SEL_W     = $clog2(NUM_SRC);
  localparam int DIV_W     = 3;
  localparam int SRC_RCF   = 2;
  localparam int RESET_DIV = 1;

  typedef struct packed {
    logic [NUM_SRC-1:0] want;
    logic               divClr;
    logic [DIV_W-1:0]   divCode;
  } pathCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_APPLY,
    ST_ENGAGE
  } swState_t;
endpackage

// File: rtl/clk_sel_branch.sv
module clk_sel_branch (
  input  logic srcClk,
  input  logic arstN,
  input  logic want,
  input  logic ready,
  input  logic othersOff,
  output logic gatedClk,
  output logic isOn
);
  logic stg1;
  logic stg2;

  // Enable changes only on the source's own falling edge.
  always_ff @(negedge srcClk or negedge arstN) begin
    if (!arstN) begin
      stg1 <= 1'b0;
      stg2 <= 1'b0;
    end else begin
      stg1 <= want & ready & othersOff;
      stg2 <= stg1;
    end
  end

  assign gatedClk = srcClk & stg2;
  assign isOn     = stg2;
endmodule

// File: rtl/clk_sel_path.sv
module clk_sel_path import clk_sel_pkg::*; (
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] oscClk,
  input  logic [NUM_SRC-1:0] oscReady,
  input  logic               revertKill,
  input  pathCtl_t           ctl,
  output logic [NUM_SRC-1:0] branchOn,
  output logic               sysClk
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [NUM_SRC-1:0] gated;
  logic [NUM_SRC-1:0] brRstN;
  logic [NUM_SRC-1:0] othersOff;
  logic               muxClk;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_branch
    localparam logic [NUM_SRC-1:0] SELF = NUM_SRC'(1) << i;
    if (i == SRC_RCF) begin : g_keep
      assign brRstN[i] = rstN;
    end else begin : g_kill
      assign brRstN[i] = rstN & ~revertKill;
    end
    assign othersOff[i] = ~|(branchOn & ~SELF);
    clk_sel_branch u_branch (
      .srcClk   (oscClk[i]),
      .arstN    (brRstN[i]),
      .want     (ctl.want[i]),
      .ready    (oscReady[i]),
      .othersOff(othersOff[i]),
      .gatedClk (gated[i]),
      .isOn     (branchOn[i])
    );
  end

  assign muxClk = |gated;

  // Prescaler: pass one mux pulse out of every 2^d.
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] divMask;
  logic             divEn;
  logic             divRstN;

  always_comb begin
    divMask = ~({CNT_W{1'b1}} << ctl.divCode);
    nextCnt = cnt + CNT_W'(1);
  end

  assign divRstN = rstN & ~ctl.divClr;

  always_ff @(negedge muxClk or negedge divRstN) begin
    if (!divRstN) begin
      cnt   <= '0;
      divEn <= 1'b1;
    end else begin
      cnt   <= nextCnt;
      divEn <= ((nextCnt & divMask) == '0);
    end
  end

  assign sysClk = muxClk & divEn;
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
  parameter int TO_W = 8
) (
  input  logic            monClk,
  input  logic            rstN,
  input  logic            sysClk,
  input  logic            busy,
  input  logic [TO_W-1:0] timeout,
  output logic            trip
);
  logic            tog;
  logic [2:0]      togSync;
  logic [1:0]      busySync;
  logic [TO_W-1:0] idleCnt;
  logic            edgeSeen;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) tog <= 1'b0;
    else       tog <= ~tog;
  end

  assign edgeSeen = togSync[2] ^ togSync[1];

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      togSync  <= '0;
      busySync <= '1;
      idleCnt  <= '0;
      trip     <= 1'b0;
    end else begin
      togSync  <= {togSync[1:0], tog};
      busySync <= {busySync[0], busy};
      if (edgeSeen || busySync[1])  idleCnt <= '0;
      else if (idleCnt != '1)       idleCnt <= idleCnt + TO_W'(1);
      if (busySync[1])              trip <= 1'b0;
      else if (idleCnt >= timeout)  trip <= 1'b1;
    end
  end
endmodule

// File: rtl/clk_sel_ctrl.sv
module clk_sel_ctrl import clk_sel_pkg::*; (
  input  logic               regClk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [DIV_W-1:0]   wrDiv,
  input  logic               trip,
  input  logic [NUM_SRC-1:0] branchOn,
  output pathCtl_t           ctl,
  output logic               switchBusy,
  output logic [SEL_W-1:0]   curSel,
  output logic [DIV_W-1:0]   curDiv,
  output logic               revertEvt
);
  localparam logic [SEL_W-1:0] RC_SEL  = SEL_W'(SRC_RCF);
  localparam logic [DIV_W-1:0] DIV_DEF = DIV_W'(RESET_DIV);

  swState_t           state, stateNx;
  logic [SEL_W-1:0]   selQ, selNx, pendSel, pendSelNx;
  logic [DIV_W-1:0]   divQ, divNx, pendDiv, pendDivNx, divLive;
  logic               pendValid, pendVNx;
  logic [NUM_SRC-1:0] onMeta, onSync;
  logic [2:0]         tripSync;
  logic [NUM_SRC-1:0] wantQ;
  logic               divClrQ;

  assign revertEvt = tripSync[1] & ~tripSync[2];

  always_comb begin
    stateNx   = state;
    selNx     = selQ;
    divNx     = divQ;
    pendVNx   = pendValid;
    pendSelNx = pendSel;
    pendDivNx = pendDiv;
    if (revertEvt) begin
      selNx   = RC_SEL;
      divNx   = DIV_DEF;
      pendVNx = 1'b0;
      stateNx = ST_DRAIN;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wrEn) begin
            selNx   = wrSel;
            divNx   = wrDiv;
            pendVNx = 1'b0;
            stateNx = ST_DRAIN;
          end else if (pendValid) begin
            selNx   = pendSel;
            divNx   = pendDiv;
            pendVNx = 1'b0;
            stateNx = ST_DRAIN;
          end
        end
        ST_DRAIN:  if (onSync == '0) stateNx = ST_APPLY;
        ST_APPLY:  stateNx = ST_ENGAGE;
        ST_ENGAGE: if (onSync[selQ]) stateNx = ST_IDLE;
        default:   stateNx = ST_IDLE;
      endcase
      if (wrEn && state != ST_IDLE) begin
        pendVNx   = 1'b1;
        pendSelNx = wrSel;
        pendDivNx = wrDiv;
      end
    end
  end

  always_ff @(posedge regClk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_ENGAGE;
      selQ      <= RC_SEL;
      divQ      <= DIV_DEF;
      divLive   <= DIV_DEF;
      pendValid <= 1'b0;
      pendSel   <= '0;
      pendDiv   <= '0;
      onMeta    <= '0;
      onSync    <= '0;
      tripSync  <= '0;
      wantQ     <= '0;
      divClrQ   <= 1'b0;
    end else begin
      state     <= stateNx;
      selQ      <= selNx;
      divQ      <= divNx;
      pendValid <= pendVNx;
      pendSel   <= pendSelNx;
      pendDiv   <= pendDivNx;
      onMeta    <= branchOn;
      onSync    <= onMeta;
      tripSync  <= {tripSync[1:0], trip};
      divClrQ   <= (stateNx == ST_APPLY);
      if (state == ST_APPLY) divLive <= divQ;
      if (stateNx == ST_IDLE || stateNx == ST_ENGAGE) wantQ <= NUM_SRC'(1) << selNx;
      else                                            wantQ <= '0;
    end
  end

  assign ctl.want    = wantQ;
  assign ctl.divClr  = divClrQ;
  assign ctl.divCode = divLive;
  assign switchBusy  = (state != ST_IDLE);
  assign curSel      = selQ;
  assign curDiv      = divQ;
endmodule

// File: rtl/clk_source_mux.sv
module clk_source_mux import clk_sel_pkg::*; #(
  parameter int TO_W = 8
) (
  input  logic               regClk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] oscClk,
  input  logic [NUM_SRC-1:0] oscReady,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [DIV_W-1:0]   wrDiv,
  input  logic [TO_W-1:0]    monTimeout,
  output logic               sysClk,
  output logic               switchBusy,
  output logic [SEL_W-1:0]   curSel,
  output logic [DIV_W-1:0]   curDiv
);
  pathCtl_t           ctl;
  logic [NUM_SRC-1:0] branchOn;
  logic               monTrip;
  logic               revertEvt;

  clk_sel_ctrl u_ctrl (
    .regClk    (regClk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrDiv     (wrDiv),
    .trip      (monTrip),
    .branchOn  (branchOn),
    .ctl       (ctl),
    .switchBusy(switchBusy),
    .curSel    (curSel),
    .curDiv    (curDiv),
    .revertEvt (revertEvt)
  );

  clk_sel_path u_path (
    .rstN      (rstN),
    .oscClk    (oscClk),
    .oscReady  (oscReady),
    .revertKill(monTrip),
    .ctl       (ctl),
    .branchOn  (branchOn),
    .sysClk    (sysClk)
  );

  clk_loss_monitor #(.TO_W(TO_W)) u_mon (
    .monClk (oscClk[SRC_RCF]),
    .rstN   (rstN),
    .sysClk (sysClk),
    .busy   (switchBusy),
    .timeout(monTimeout),
    .trip   (monTrip)
  );
endmodule

// File: rtl/clk_source_mux_chk.sv
module clk_source_mux_chk import clk_sel_pkg::*; (
  input logic               regClk,
  input logic               rstN,
  input logic               wrEn,
  input logic [SEL_W-1:0]   wrSel,
  input logic [DIV_W-1:0]   wrDiv,
  input logic               switchBusy,
  input logic [SEL_W-1:0]   curSel,
  input logic [DIV_W-1:0]   curDiv,
  input logic [NUM_SRC-1:0] branchOn,
  input logic               revertEvt,
  input logic               monTrip
);
  a_r4_single_source: assert property (@(posedge regClk) disable iff (!rstN)
    $onehot0(branchOn));

  a_r5_write_lands: assert property (@(posedge regClk) disable iff (!rstN)
    (wrEn && !switchBusy && !revertEvt) |=>
      (switchBusy && curSel == $past(wrSel) && curDiv == $past(wrDiv)));

  a_r7_frozen_while_busy: assert property (@(posedge regClk) disable iff (!rstN)
    (switchBusy && !revertEvt) |=> ($stable(curSel) && $stable(curDiv)));

  a_r8_revert_default: assert property (@(posedge regClk) disable iff (!rstN)
    revertEvt |=> (switchBusy && curSel == SEL_W'(SRC_RCF) && curDiv == DIV_W'(RESET_DIV)));

  a_r2_idle_branch_on: assert property (@(posedge regClk) disable iff (!rstN)
    (!switchBusy && !monTrip && !revertEvt) |-> branchOn[curSel]);
endmodule

bind clk_source_mux clk_source_mux_chk u_chk (
  .regClk    (regClk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrSel     (wrSel),
  .wrDiv     (wrDiv),
  .switchBusy(switchBusy),
  .curSel    (curSel),
  .curDiv    (curDiv),
  .branchOn  (branchOn),
  .revertEvt (revertEvt),
  .monTrip   (monTrip)
);

// File: tb/clk_source_mux_tb.sv
`timescale 1ns/1ps
module clk_source_mux_tb;
  localparam int HALF [4] = '{13, 47, 23, 75};
  localparam int NV = 8;
  // {sel[4:3], div[2:0]}
  localparam logic [4:0] VECS [NV] = '{5'b00000, 5'b00011, 5'b01001, 5'b11000,
                                       5'b10010, 5'b00001, 5'b11010, 5'b01011};

  logic regClk = 1'b0;
  logic rstN = 1'b1;
  logic osc0 = 1'b0, osc1 = 1'b0, osc2 = 1'b0, osc3 = 1'b0;
  logic stop0 = 1'b0;
  logic [3:0] oscReady = 4'b1111;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [2:0] wrDiv = '0;
  logic [7:0] monTimeout = 8'd40;
  logic sysClk, switchBusy;
  logic [1:0] curSel;
  logic [2:0] curDiv;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  realtime lastRise = 0, lastFall = 0;
  realtime minHigh = 1.0e9, minLow = 1.0e9;
  bit seenRise = 1'b0, seenFall = 1'b0;

  clk_source_mux u_dut (
    .regClk(regClk), .rstN(rstN), .oscClk({osc3, osc2, osc1, osc0}),
    .oscReady(oscReady), .wrEn(wrEn), .wrSel(wrSel), .wrDiv(wrDiv),
    .monTimeout(monTimeout), .sysClk(sysClk), .switchBusy(switchBusy),
    .curSel(curSel), .curDiv(curDiv)
  );

  always #10 regClk = ~regClk;
  always begin #13; if (!stop0) osc0 = ~osc0; end
  always begin #47; osc1 = ~osc1; end
  always begin #23; osc2 = ~osc2; end
  always begin #75; osc3 = ~osc3; end

  // R4: pulse width tracking on the output
  always @(posedge sysClk) begin
    if (seenFall && ($realtime - lastFall) < minLow) minLow = $realtime - lastFall;
    lastRise = $realtime; seenRise = 1'b1;
  end
  always @(negedge sysClk) begin
    if (seenRise && ($realtime - lastRise) < minHigh) minHigh = $realtime - lastRise;
    lastFall = $realtime; seenFall = 1'b1;
  end

  task automatic chkInt(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkReal(input string req, input string what, input real act, input real exp);
    checks++;
    if ((act > exp ? act - exp : exp - act) > 0.01) begin
      fails++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] s, input logic [2:0] d);
    @(negedge regClk); wrEn = 1'b1; wrSel = s; wrDiv = d;
    @(negedge regClk); wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int run = 0;
    while (run < 4) begin
      @(negedge regClk);
      if (!switchBusy) run++; else run = 0;
    end
  endtask

  task automatic measure(output real per, output real hi);
    realtime t0, t1, t2;
    @(posedge sysClk); t0 = $realtime;
    @(negedge sysClk); t1 = $realtime;
    @(posedge sysClk); t2 = $realtime;
    per = t2 - t0; hi = t1 - t0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    real per, hi;
    #1 rstN = 1'b0;
    repeat (5) @(negedge regClk);
    rstN = 1'b1;
    @(negedge regClk);
    // R1: reset state
    chkInt("R1", "reset sel", int'(curSel), 2);
    chkInt("R1", "reset div", int'(curDiv), 1);
    chkInt("R1", "busy after reset", int'(switchBusy), 1);
    waitIdle();
    measure(per, hi);
    chkReal("R1", "reset period", per, 4.0 * HALF[2]);

    // Table walk: R2, R3, R5, R9
    for (int v = 0; v < NV; v++) begin
      logic [1:0] s;
      logic [2:0] d;
      s = VECS[v][4:3]; d = VECS[v][2:0];
      doWrite(s, d);
      chkInt("R5", "sel after write", int'(curSel), int'(s));
      chkInt("R5", "busy after write", int'(switchBusy), 1);
      waitIdle();
      measure(per, hi);
      chkReal("R2", "period", per, 2.0 * HALF[s] * real'(1 << d));
      chkReal("R3", "high phase", hi, real'(HALF[s]));
      repeat (20) @(negedge regClk);
      chkInt("R9", "setting kept", int'({curSel, curDiv}), int'({s, d}));
    end

    // R6: source not ready
    oscReady[0] = 1'b0;
    doWrite(2'd0, 3'd0);
    repeat (100) @(negedge regClk);
    chkInt("R6", "busy while not ready", int'(switchBusy), 1);
    oscReady[0] = 1'b1;
    waitIdle();
    measure(per, hi);
    chkReal("R6", "period after ready", per, 26.0);

    // R7: write during a change is held
    doWrite(2'd1, 3'd0);
    doWrite(2'd0, 3'd2);
    chkInt("R7", "sel held", int'(curSel), 1);
    chkInt("R7", "div held", int'(curDiv), 0);
    waitIdle();
    chkInt("R7", "held sel applied", int'(curSel), 0);
    chkInt("R7", "held div applied", int'(curDiv), 2);
    measure(per, hi);
    chkReal("R7", "held period", per, 104.0);

    // R4: pulse widths across all changes so far
    chkInt("R4", "min high >= 13ns", int'(minHigh >= 12.99), 1);
    chkInt("R4", "min low >= 13ns", int'(minLow >= 12.99), 1);

    // R8: stopped crystal reverts to fast RC
    doWrite(2'd0, 3'd0);
    waitIdle();
    stop0 = 1'b1;
    for (int c = 0; c < 400 && curSel != 2'd2; c++) @(negedge regClk);
    chkInt("R8", "revert sel", int'(curSel), 2);
    chkInt("R8", "revert div", int'(curDiv), 1);
    waitIdle();
    measure(per, hi);
    chkReal("R8", "period after revert", per, 92.0);
    finishRun();
  end
endmodule